// File: doc/BRIEF.md
# E3 Transmit Overhead Byte Inserter

This block sits in a byte-wide E3 transmit path and rewrites the overhead positions of every outgoing frame. Position 0 carries the first framing octet (nominal 0xF6) and position 1 the second (nominal 0x28). Each is XORed with its own programmable 8-bit error mask before it leaves, so test equipment can inject framing errors on purpose. A trail-trace byte at a parameterised position carries one entry per frame from a 16-byte identifier buffer. The buffer is walked over a 16-frame cycle and then repeats, which lets the far end confirm that it is wired to the right source.

Frames are located by a start-of-frame strobe that marks position 0. After the first strobe a byte counter free-runs over `FRAME_LEN` bytes. A later strobe restarts the frame at once. Four states track the position: `ST_HUNT` (no strobe seen since reset, every byte passes through), `ST_FA1` (next byte is the first framing octet), `ST_FA2` (next byte is the second framing octet) and `ST_BODY` (counting payload positions). The transitions are as follows. A strobe in any state goes to `ST_FA2`. `ST_FA1` goes to `ST_FA2` and `ST_FA2` goes to `ST_BODY` on each valid byte. `ST_BODY` goes to `ST_FA1` after position `FRAME_LEN-1`. `ST_HUNT` stays in place until a strobe arrives. Bytes with `in_valid` low change no state.

A byte-wide register port holds the identifier and the masks. Address 0 to 15 selects a trace entry, 16 selects the first mask and 17 the second. The output is registered with one cycle of latency.

Top module: `e3oh_inserter`

## Requirements
- R1: After reset, all 18 registers read 0x00, and `out_valid` and `out_data` are 0.
- R2: Every byte that is not an overhead byte leaves unchanged, including all bytes before the first start-of-frame strobe.
- R3: The byte at position 0 leaves as 0xF6 XOR the mask at address 16, using the mask value held when that byte enters.
- R4: The byte at position 1 leaves as 0x28 XOR the mask at address 17.
- R5: The byte at position `TR_POS` carries trace entry n mod 16 in the n-th frame after reset (n from 0), so entry 0 goes in the first frame and entry 15 is followed by entry 0.
- R6: The trace entry for a frame is captured when that frame's position-0 byte enters. A register write made after that point does not alter the frame's trace byte, but it does appear when that slot next comes round.
- R7: After `FRAME_LEN` bytes the next byte is position 0 without a strobe, and a strobe at any position restarts the frame at position 0.
- R8: `out_valid` equals `in_valid` one cycle earlier, and `out_data` is the processed byte from that cycle. Cycles with `in_valid` low do not advance the frame position.
- R9: `reg_rdata` returns trace entry `reg_addr` for addresses 0 to 15 and the masks at 16 and 17. It returns 0x00 elsewhere, and writes to addresses 18 to 31 change nothing.
- R10: With both masks zero, the framing octets leave as exactly 0xF6 and 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_sof | input | 1 | Input byte is frame position 0 |
| in_data | input | 8 | Input byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (0-15 trace, 16/17 masks) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |

## Verification
A wrong position state shows up within one frame: a framing octet or trace byte appears at the wrong offset, or a payload byte is overwritten. A wrong trace index shows up as the wrong entry in the very next frame's trace byte, and a wrap fault shows up in the 17th frame. A capture register that follows writes too eagerly shows up in the frame that is in flight when the write lands. A mask routed to the wrong octet shows up on the first frame after a non-zero mask is written.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
    localparam int TRACE_LEN = 16;
    localparam int IDX_W     = $clog2(TRACE_LEN);
    localparam int ADDR_W    = 5;
    localparam logic [ADDR_W-1:0] ADDR_MASK1 = 5'd16;
    localparam logic [ADDR_W-1:0] ADDR_MASK2 = 5'd17;
    localparam logic [7:0] FA1_NOM = 8'hF6;
    localparam logic [7:0] FA2_NOM = 8'h28;

    typedef enum logic [1:0] {ST_HUNT, ST_FA1, ST_FA2, ST_BODY} pos_state_t;
    typedef enum logic [1:0] {K_PASS, K_FA1, K_FA2, K_TR} byte_kind_t;
endpackage

// File: rtl/e3oh_regfile.sv
module e3oh_regfile
    import e3oh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [IDX_W-1:0]  tr_idx,
    output logic [7:0]        tr_byte,
    output logic [7:0]        mask1,
    output logic [7:0]        mask2
);
    logic [7:0] trace_q [TRACE_LEN];

    generate
        for (genvar i = 0; i < TRACE_LEN; i++) begin : g_trace
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    trace_q[i] <= 8'h00;
                else if (reg_we && reg_addr == ADDR_W'(i))
                    trace_q[i] <= reg_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask1 <= 8'h00;
            mask2 <= 8'h00;
        end else if (reg_we) begin
            if (reg_addr == ADDR_MASK1) mask1 <= reg_wdata;
            if (reg_addr == ADDR_MASK2) mask2 <= reg_wdata;
        end
    end

    always_comb begin
        if (reg_addr < ADDR_W'(TRACE_LEN))
            reg_rdata = trace_q[reg_addr[IDX_W-1:0]];
        else if (reg_addr == ADDR_MASK1)
            reg_rdata = mask1;
        else if (reg_addr == ADDR_MASK2)
            reg_rdata = mask2;
        else
            reg_rdata = 8'h00;
    end

    assign tr_byte = trace_q[tr_idx];

    p_mask1_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_MASK1) |=> (mask1 == $past(reg_wdata)));
    p_mask2_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_MASK2) |=> $stable(mask2));
endmodule

// File: rtl/e3oh_pos_fsm.sv
module e3oh_pos_fsm
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = 537,
    parameter int TR_POS    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    output byte_kind_t kind
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TR_CNT   = CNT_W'(TR_POS);

    pos_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_valid) begin
            if (in_sof) begin
                state_d = ST_FA2;
                cnt_d   = CNT_W'(1);
            end else begin
                unique case (state_q)
                    ST_HUNT: state_d = ST_HUNT;
                    ST_FA1: begin
                        state_d = ST_FA2;
                        cnt_d   = CNT_W'(1);
                    end
                    ST_FA2: begin
                        state_d = ST_BODY;
                        cnt_d   = CNT_W'(2);
                    end
                    ST_BODY: begin
                        if (cnt_q == LAST_POS) begin
                            state_d = ST_FA1;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        kind = K_PASS;
        if (in_sof) begin
            kind = K_FA1;
        end else begin
            unique case (state_q)
                ST_HUNT: kind = K_PASS;
                ST_FA1:  kind = K_FA1;
                ST_FA2:  kind = K_FA2;
                ST_BODY: kind = (cnt_q == TR_CNT) ? K_TR : K_PASS;
            endcase
        end
    end

    p_fa1_then_fa2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_FA1) |=> (state_q == ST_FA2));
    p_body_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY) |-> (cnt_q >= CNT_W'(2) && cnt_q <= LAST_POS));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/e3oh_inserter.sv
module e3oh_inserter
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = 537,
    parameter int TR_POS    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_data,
    input  logic       reg_we,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       out_valid,
    output logic [7:0] out_data
);
    byte_kind_t       kind;
    logic [IDX_W-1:0] tr_idx_q;
    logic [7:0]       tr_byte, tr_hold_q, mask1, mask2, byte_d;

    e3oh_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tr_idx    (tr_idx_q),
        .tr_byte   (tr_byte),
        .mask1     (mask1),
        .mask2     (mask2)
    );

    e3oh_pos_fsm #(.FRAME_LEN(FRAME_LEN), .TR_POS(TR_POS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .kind     (kind)
    );

    // Trace entry captured at the start of each frame; later writes wait a round.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_idx_q  <= '0;
            tr_hold_q <= 8'h00;
        end else if (in_valid && kind == K_FA1) begin
            tr_idx_q  <= tr_idx_q + 1'b1;
            tr_hold_q <= tr_byte;
        end
    end

    always_comb begin
        unique case (kind)
            K_FA1:   byte_d = FA1_NOM ^ mask1;
            K_FA2:   byte_d = FA2_NOM ^ mask2;
            K_TR:    byte_d = tr_hold_q;
            default: byte_d = in_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= byte_d;
        end
    end

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_PASS) |=> (out_data == $past(in_data)));
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_FA1) |=> (tr_idx_q == $past(tr_idx_q) + 1'b1));
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && kind == K_FA1) |=> $stable(tr_hold_q));
    p_fa1_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_FA1) |=> ((out_data ^ $past(mask1)) == FA1_NOM));
endmodule

// File: tb/e3oh_inserter_tb.sv
`timescale 1ns/1ps
module e3oh_inserter_tb;
    localparam int FL = 40;
    localparam int TP = 6;

    // {mask1, mask2, expected first octet, expected second octet}
    localparam logic [31:0] MASK_VEC [4] = '{
        32'h00_00_F6_28, 32'hFF_00_09_28, 32'h01_80_F7_A8, 32'h5A_28_AC_00
    };
    localparam logic [7:0] TRACE_VEC [16] = '{
        8'h8C, 8'h2B, 8'h34, 8'h39, 8'h33, 8'h30, 8'h31, 8'h32,
        8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 8'h41
    };

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sof = 0, reg_we = 0;
    logic [7:0] in_data = 0, reg_wdata = 0;
    logic [4:0] reg_addr = 0;
    logic [7:0] reg_rdata, out_data;
    logic out_valid;

    int checks = 0, errors = 0, nfr = 0;
    logic [7:0] exp_tr [16];
    logic [7:0] got_fa1, got_fa2, got_tr;
    int pbad, vbad;

    always #10 clk = ~clk;

    e3oh_inserter #(.FRAME_LEN(FL), .TR_POS(TP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] pat(int p);
        return 8'((p * 7 + 3) ^ (nfr * 13));
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        in_valid = 0; in_sof = 0; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic run_frame(bit use_sof, int wr_pos, logic [4:0] wa, logic [7:0] wd, int bub);
        pbad = 0; vbad = 0;
        for (int p = 0; p < FL; p++) begin
            if (p == bub) begin
                @(negedge clk);
                in_valid = 0; in_sof = 0; in_data = 8'hEE; reg_we = 0;
                @(posedge clk); #1;
                chk("R8 idle", {7'd0, out_valid}, 8'd0);
            end
            @(negedge clk);
            in_valid = 1; in_sof = use_sof && p == 0; in_data = pat(p);
            reg_we = (p == wr_pos); reg_addr = wa; reg_wdata = wd;
            @(posedge clk); #1;
            if (!out_valid) vbad++;
            if (p == 0) got_fa1 = out_data;
            else if (p == 1) got_fa2 = out_data;
            else if (p == TP) got_tr = out_data;
            else if (out_data !== pat(p)) pbad++;
        end
        chk("R2 payload", 8'(pbad), 8'd0);
        chk("R8 valid", 8'(vbad), 8'd0);
        nfr++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_sof = 0; reg_we = 0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_tr[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
        chk("R1 out_data", out_data, 8'h00);
        for (int a = 0; a < 18; a++) begin
            reg_addr = 5'(a); #1;
            chk("R1 reg", reg_rdata, 8'h00);
        end
        @(negedge clk); rst_n = 1;

        // R2 bytes before any strobe pass untouched
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); in_valid = 1; in_sof = 0; in_data = 8'hF0 + 8'(p);
            @(posedge clk); #1;
            chk("R2 hunt", out_data, 8'hF0 + 8'(p));
        end
        idle();

        // R9 load the identifier and read it back
        for (int i = 0; i < 16; i++) begin
            reg_write(5'(i), TRACE_VEC[i]);
            exp_tr[i] = TRACE_VEC[i];
        end
        for (int i = 0; i < 16; i++) begin
            reg_addr = 5'(i); #1;
            chk("R9 readback", reg_rdata, TRACE_VEC[i]);
        end

        // R5/R7/R10: 17 frames, strobe only on the first, bubble in one
        for (int f = 0; f < 17; f++) begin
            run_frame(f == 0, -1, 0, 0, (f == 3) ? 4 : -1);
            chk("R10 fa1", got_fa1, 8'hF6);
            chk("R10 fa2", got_fa2, 8'h28);
            chk("R5 trace", got_tr, exp_tr[(nfr - 1) % 16]);
        end

        // R3/R4 mask vectors
        for (int v = 0; v < 4; v++) begin
            idle();
            reg_write(5'd16, MASK_VEC[v][31:24]);
            reg_write(5'd17, MASK_VEC[v][23:16]);
            run_frame(1, -1, 0, 0, -1);
            chk("R3 fa1 mask", got_fa1, MASK_VEC[v][15:8]);
            chk("R4 fa2 mask", got_fa2, MASK_VEC[v][7:0]);
            chk("R5 trace", got_tr, exp_tr[(nfr - 1) % 16]);
        end
        idle();
        reg_write(5'd16, 8'h00);
        reg_write(5'd17, 8'h00);

        // R6 write to the slot in flight after capture
        begin
            int slot;
            slot = nfr % 16;
            run_frame(1, 3, 5'(slot), 8'hA5, -1);
            chk("R6 in-flight", got_tr, exp_tr[slot]);
            exp_tr[slot] = 8'hA5;
            for (int f = 0; f < 16; f++) begin
                run_frame(0, -1, 0, 0, -1);
                chk("R6 next round", got_tr, exp_tr[(nfr - 1) % 16]);
            end
        end

        // R7 strobe mid-frame restarts the frame
        for (int p = 0; p < 10; p++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (p == 0); in_data = 8'h11; reg_we = 0;
            @(posedge clk); #1;
            if (p == TP) chk("R5 short frame", out_data, exp_tr[nfr % 16]);
        end
        nfr++;
        run_frame(1, -1, 0, 0, -1);
        chk("R7 resync fa1", got_fa1, 8'hF6);
        chk("R7 resync fa2", got_fa2, 8'h28);
        chk("R7 resync trace", got_tr, exp_tr[(nfr - 1) % 16]);
        idle();

        // R9 out-of-map address
        reg_write(5'd20, 8'h55);
        reg_addr = 5'd20; #1;
        chk("R9 unmapped", reg_rdata, 8'h00);
        reg_addr = 5'd16; #1;
        chk("R9 mask1 intact", reg_rdata, 8'h00);
        reg_addr = 5'd2; #1;
        chk("R9 trace intact", reg_rdata, exp_tr[2]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule